// File: doc/BRIEF.md
# Synthesizer Control Word Loader

This block gathers a 40-bit control word for a direct digital synthesis core from a host processor. The word has two parts. The first is a control byte that holds a phase offset, a power-down request and two format bits. The second is a 32-bit frequency tuning word. The host fills the word in one of two ways:

- **Parallel:** one byte per write on an 8-bit data port.
- **Serial:** one bit per write on the top data line.

Each write is marked by a word strobe. An update strobe then copies the word that has been assembled into the active register, which drives the synthesis core.

Both host strobes are asynchronous to the reference clock. Each passes through a two-flop synchronizer and an edge detector, so every rising edge of a strobe counts as exactly one action. The input register keeps its contents across master reset. An update that follows a reset, or follows an incomplete load, therefore re-issues whatever the input register last held.

Top module: `dds_word_loader`

## Requirements
- R1: While `rst` is high, and right after it is released, `phaseOffset`, `powerDown`, `loadFormat` and `tuningWord` are all zero, and the byte slot pointer is back at slot 0.
- R2: In parallel mode (`serialMode` = 0), successive writes fill slot 0 (the control byte) and then slots 1 to 4 (the tuning word, most significant byte first). In the control byte, bits [7:3] are the phase offset, bit 2 is power-down and bits [1:0] are the format bits.
- R3: The active outputs change only on an update. An update copies the input register to them: phase offset, power-down and format come from bits [39:35], [34] and [33:32], and the tuning word comes from bits [31:0].
- R4: An update rewinds the slot pointer, so the next parallel write lands in the control byte.
- R5: Parallel writes that arrive after the fifth byte and before an update are ignored.
- R6: An update after an incomplete parallel load transfers the new bytes together with the bytes the input register held before.
- R7: In serial mode (`serialMode` = 1), each write shifts `dataIn[7]` into bit 39 while the register moves one place toward bit 0. Forty writes therefore place the first bit in tuning word bit 0 and the last bit in control bit 7.
- R8: Master reset leaves the input register intact. An update issued right after reset transfers the word loaded before the reset.
- R9: A strobe rising edge acts on the third reference clock edge after the strobe is first seen high. A strobe held high over many cycles acts only once.
- R10: When a write and an update take effect in the same cycle, three things happen. The update transfers the register contents from before that write. The written byte is still stored in the slot the pointer held. The pointer returns to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| dataIn | input | 8 | Host data byte; bit 7 is the serial data line |
| wrStrobe | input | 1 | Word-load strobe from the host, asynchronous |
| updStrobe | input | 1 | Update strobe from the host, asynchronous |
| serialMode | input | 1 | 1 selects bit-serial loading, 0 selects byte loading |
| phaseOffset | output | 5 | Active phase offset |
| powerDown | output | 1 | Active power-down request |
| loadFormat | output | 2 | Active format bits |
| tuningWord | output | 32 | Active frequency tuning word |

## Verification
A write and an update can land in the same cycle. The input register then takes a byte while the active register copies it, and the pointer is asked both to advance and to rewind. The bench provokes this by raising both strobes on the same clock after four bytes of a load. It expects the active word to hold the pre-write contents. A later control-byte write followed by an update must then show that the colliding byte went to slot 4 and that the pointer was rewound.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
  // per-cycle actions issued by the control to the datapath
  typedef struct packed {
    logic wrPar;  // store dataIn into the slot addressed by the pointer
    logic wrSer;  // shift the serial bit in at the top
    logic xfer;   // copy input register to active register
  } ldr_ctl_t;

  localparam int FMT_W = 2;  // format bits at the bottom of the control byte
  localparam int PD_POS = 2; // power-down bit position in the control byte
endpackage

// File: rtl/dds_ldr_ctrl.sv
module dds_ldr_ctrl
  import dds_ldr_pkg::*;
#(
  parameter int NUM_BYTES   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrStrobe,
  input  logic             updStrobe,
  input  logic             serialMode,
  output ldr_ctl_t         ctl,
  output logic [PTR_W-1:0] slotPtr
);
  // index 0 is the first synchronizer stage; the last stage holds the previous value
  logic [SYNC_STAGES:0] wrSync;
  logic [SYNC_STAGES:0] updSync;
  logic                 wrRise;
  logic                 updRise;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wrSync  <= '0;
      updSync <= '0;
    end else begin
      wrSync  <= {wrSync[SYNC_STAGES-1:0], wrStrobe};
      updSync <= {updSync[SYNC_STAGES-1:0], updStrobe};
    end
  end

  assign wrRise  = wrSync[SYNC_STAGES-1] & ~wrSync[SYNC_STAGES];
  assign updRise = updSync[SYNC_STAGES-1] & ~updSync[SYNC_STAGES];

  always_comb begin
    ctl.wrPar = wrRise & ~serialMode & (slotPtr < PTR_W'(NUM_BYTES));
    ctl.wrSer = wrRise & serialMode;
    ctl.xfer  = updRise;
  end

  // pointer advances per parallel byte, saturates at NUM_BYTES, rewound by update
  always_ff @(posedge clk or posedge rst) begin
    if (rst)            slotPtr <= '0;
    else if (ctl.xfer)  slotPtr <= '0;
    else if (ctl.wrPar) slotPtr <= slotPtr + PTR_W'(1);
  end
endmodule

// File: rtl/dds_ldr_datapath.sv
module dds_ldr_datapath
  import dds_ldr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BYTES = 5,
  parameter int PTR_W     = $clog2(NUM_BYTES + 1),
  localparam int WORD_W   = DATA_W * NUM_BYTES,
  localparam int FTW_W    = WORD_W - DATA_W,
  localparam int PHASE_W  = DATA_W - FMT_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ldr_ctl_t           ctl,
  input  logic [PTR_W-1:0]   slotPtr,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [WORD_W-1:0]  inWord,
  output logic [PHASE_W-1:0] phaseOffset,
  output logic               powerDown,
  output logic [FMT_W-1:0]   loadFormat,
  output logic [FTW_W-1:0]   tuningWord
);
  logic [NUM_BYTES-1:0] laneHit;
  logic [WORD_W-1:0]    nextIn;
  logic [WORD_W-1:0]    activeWord;

  // one decoded lane per byte slot; slot 0 is the most significant byte
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign laneHit[g] = ctl.wrPar && (slotPtr == PTR_W'(g));
  end

  always_comb begin
    nextIn = inWord;
    if (ctl.wrSer) begin
      nextIn = {dataIn[DATA_W-1], inWord[WORD_W-1:1]};
    end else begin
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (laneHit[i]) nextIn[WORD_W-1-i*DATA_W -: DATA_W] = dataIn;
      end
    end
  end

  // input register: deliberately outside master reset
  always_ff @(posedge clk) begin
    inWord <= nextIn;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           activeWord <= '0;
    else if (ctl.xfer) activeWord <= inWord;
  end

  assign phaseOffset = activeWord[WORD_W-1 -: PHASE_W];
  assign powerDown   = activeWord[FTW_W + PD_POS];
  assign loadFormat  = activeWord[FTW_W +: FMT_W];
  assign tuningWord  = activeWord[FTW_W-1:0];
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_ldr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_BYTES   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(NUM_BYTES + 1),
  localparam int WORD_W     = DATA_W * NUM_BYTES,
  localparam int FTW_W      = WORD_W - DATA_W,
  localparam int PHASE_W    = DATA_W - FMT_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               wrStrobe,
  input  logic               updStrobe,
  input  logic               serialMode,
  output logic [PHASE_W-1:0] phaseOffset,
  output logic               powerDown,
  output logic [FMT_W-1:0]   loadFormat,
  output logic [FTW_W-1:0]   tuningWord
);
  ldr_ctl_t          ctl;
  logic [PTR_W-1:0]  slotPtr;
  logic [WORD_W-1:0] inWord;

  dds_ldr_ctrl #(
    .NUM_BYTES(NUM_BYTES), .SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .updStrobe(updStrobe),
    .serialMode(serialMode), .ctl(ctl), .slotPtr(slotPtr)
  );

  dds_ldr_datapath #(
    .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .slotPtr(slotPtr), .dataIn(dataIn),
    .inWord(inWord), .phaseOffset(phaseOffset), .powerDown(powerDown),
    .loadFormat(loadFormat), .tuningWord(tuningWord)
  );
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk #(
  parameter int NUM_BYTES = 5,
  parameter int PTR_W     = 3,
  parameter int FTW_W     = 32,
  parameter int OUT_W     = 40
) (
  input logic             clk,
  input logic             rst,
  input logic             wrPar,
  input logic             wrSer,
  input logic             xfer,
  input logic [PTR_W-1:0] slotPtr,
  input logic [FTW_W-1:0] inFtw,
  input logic [FTW_W-1:0] tuningWord,
  input logic [OUT_W-1:0] activeAll
);
  // R1: outputs are cleared while reset is held
  always @(posedge clk) begin
    if (rst) a_r1_reset_clear: assert (activeAll == '0 && slotPtr == '0)
      else $error("R1 outputs not cleared in reset");
  end

  // R3: without an update the active outputs hold
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(activeAll));

  // R3: an update copies the input register's tuning word
  a_r3_transfer: assert property (@(posedge clk) disable iff (rst)
    xfer |=> tuningWord == $past(inFtw));

  // R4: an update rewinds the pointer
  a_r4_rewind: assert property (@(posedge clk) disable iff (rst)
    xfer |=> slotPtr == '0);

  // R2: a parallel write advances the pointer by one
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (wrPar && !xfer) |=> slotPtr == PTR_W'($past(slotPtr) + PTR_W'(1)));

  // R5: pointer never passes the slot count and stays there until update
  a_r5_bound: assert property (@(posedge clk) disable iff (rst)
    slotPtr <= PTR_W'(NUM_BYTES));
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (slotPtr == PTR_W'(NUM_BYTES) && !xfer) |=> slotPtr == PTR_W'(NUM_BYTES));

  // R9: a strobe edge yields a one-cycle write action
  a_r9_single_write: assert property (@(posedge clk) disable iff (rst)
    (wrPar || wrSer) |=> !(wrPar || wrSer));
endmodule

bind dds_word_loader dds_word_loader_chk #(
  .NUM_BYTES(NUM_BYTES), .PTR_W(PTR_W), .FTW_W(FTW_W), .OUT_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst), .wrPar(ctl.wrPar), .wrSer(ctl.wrSer), .xfer(ctl.xfer),
  .slotPtr(slotPtr), .inFtw(inWord[FTW_W-1:0]), .tuningWord(tuningWord),
  .activeAll({phaseOffset, powerDown, loadFormat, tuningWord})
);

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  dataIn = '0;
  logic        wrStrobe = 1'b0;
  logic        updStrobe = 1'b0;
  logic        serialMode = 1'b0;
  logic [4:0]  phaseOffset;
  logic        powerDown;
  logic [1:0]  loadFormat;
  logic [31:0] tuningWord;

  dds_word_loader uut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .wrStrobe(wrStrobe),
    .updStrobe(updStrobe), .serialMode(serialMode), .phaseOffset(phaseOffset),
    .powerDown(powerDown), .loadFormat(loadFormat), .tuningWord(tuningWord)
  );

  always #10 clk = ~clk;

  int    nTests = 0;
  int    nFail = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference: pending actions, input word, pointer, active word
  int          wrDue[$];
  logic [7:0]  wrDat[$];
  bit          wrSerQ[$];
  int          updDue[$];
  logic [39:0] mIn = '0;
  int          mPtr = 0;
  logic [39:0] mAct = '0;

  always @(posedge clk) begin
    logic [39:0] old;
    cyc++;
    if (!rst) begin
      old = mIn;
      if (wrDue.size() > 0 && wrDue[0] == cyc) begin
        if (wrSerQ[0]) mIn = {wrDat[0][7], mIn[39:1]};
        else if (mPtr < 5) begin
          mIn[39 - mPtr*8 -: 8] = wrDat[0];
          mPtr++;
        end
        void'(wrDue.pop_front()); void'(wrDat.pop_front()); void'(wrSerQ.pop_front());
      end
      if (updDue.size() > 0 && updDue[0] == cyc) begin
        mAct = old;
        mPtr = 0;
        void'(updDue.pop_front());
      end
    end
  end

  // cycle comparison, sampled mid-cycle
  always @(posedge clk) begin
    #5;
    if (!done) begin
      nTests++;
      if ({phaseOffset, powerDown, loadFormat, tuningWord} !== mAct) begin
        nFail++;
        $display("FAIL %s cycle %0d: actual %h expected %h", curReq, cyc,
                 {phaseOffset, powerDown, loadFormat, tuningWord}, mAct);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit w, input bit u, input logic [7:0] b, input int hold);
    @(negedge clk);
    dataIn = b;
    if (w) begin
      wrStrobe = 1'b1;
      wrDue.push_back(cyc + 3); wrDat.push_back(b); wrSerQ.push_back(serialMode);
    end
    if (u) begin
      updStrobe = 1'b1;
      updDue.push_back(cyc + 3);
    end
    repeat (hold) @(negedge clk);
    wrStrobe = 1'b0;
    updStrobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wrByte(input logic [7:0] b); strobe(1'b1, 1'b0, b, 4); endtask
  task automatic update(); strobe(1'b0, 1'b1, 8'h00, 4); endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    mAct = '0; mPtr = 0;
    wrDue.delete(); wrDat.delete(); wrSerQ.delete(); updDue.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chkCtl(input string req, input logic [4:0] ph, input logic pd,
                        input logic [1:0] fm, input logic [31:0] ftw);
    chk(req, {59'd0, phaseOffset}, {59'd0, ph});
    chk(req, {63'd0, powerDown}, {63'd0, pd});
    chk(req, {62'd0, loadFormat}, {62'd0, fm});
    chk(req, {32'd0, tuningWord}, {32'd0, ftw});
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    curReq = "R1";
    chkCtl("R1 reset state", 5'd0, 1'b0, 2'd0, 32'h0);

    // R2 / R3: full parallel load; control byte A5 -> phase 20, pd 1, fmt 1
    curReq = "R2";
    wrByte(8'hA5); wrByte(8'h12); wrByte(8'h34); wrByte(8'h56); wrByte(8'h78);
    chkCtl("R3 no change before update", 5'd0, 1'b0, 2'd0, 32'h0);
    curReq = "R3";
    update();
    chkCtl("R2 parallel word transferred", 5'd20, 1'b1, 2'd1, 32'h12345678);

    // R9: latency of an update edge
    curReq = "R9";
    wrByte(8'h00); wrByte(8'hDE); wrByte(8'hAD); wrByte(8'hBE); wrByte(8'hEF);
    @(negedge clk);
    updStrobe = 1'b1;
    updDue.push_back(cyc + 3);
    @(posedge clk); #5; chk("R9 edge 1 old", {32'd0, tuningWord}, {32'd0, 32'h12345678});
    @(posedge clk); #5; chk("R9 edge 2 old", {32'd0, tuningWord}, {32'd0, 32'h12345678});
    @(posedge clk); #5; chk("R9 edge 3 new", {32'd0, tuningWord}, {32'd0, 32'hDEADBEEF});
    repeat (10) @(negedge clk);
    updStrobe = 1'b0;
    repeat (3) @(negedge clk);

    // R9: long write strobe counts once
    strobe(1'b1, 1'b0, 8'h08, 14);
    wrByte(8'h01); wrByte(8'h02); wrByte(8'h03); wrByte(8'h04);
    update();
    chkCtl("R9 held strobe acts once", 5'd1, 1'b0, 2'd0, 32'h01020304);

    // R5: extra writes ignored
    curReq = "R5";
    wrByte(8'h10); wrByte(8'hAA); wrByte(8'hBB); wrByte(8'hCC); wrByte(8'hDD);
    wrByte(8'h99); wrByte(8'h77);
    update();
    chkCtl("R5 sixth/seventh bytes ignored", 5'd2, 1'b0, 2'd0, 32'hAABBCCDD);

    // R6: partial load keeps old bytes
    curReq = "R6";
    wrByte(8'hF8); wrByte(8'h55);
    update();
    chkCtl("R6 partial load", 5'd31, 1'b0, 2'd0, 32'h55BBCCDD);

    // R4: pointer rewound, next byte is the control byte
    curReq = "R4";
    wrByte(8'h03);
    update();
    chkCtl("R4 rewind to control byte", 5'd0, 1'b0, 2'd3, 32'h55BBCCDD);

    // R8: reset clears outputs but keeps input register
    curReq = "R8";
    doReset();
    chkCtl("R1 reset clears active", 5'd0, 1'b0, 2'd0, 32'h0);
    update();
    chkCtl("R8 input register kept over reset", 5'd0, 1'b0, 2'd3, 32'h55BBCCDD);

    // R10: write and update in the same cycle
    curReq = "R10";
    wrByte(8'h48); wrByte(8'h11); wrByte(8'h22); wrByte(8'h33);
    strobe(1'b1, 1'b1, 8'h44, 4);
    chkCtl("R10 update takes pre-write word", 5'd9, 1'b0, 2'd0, 32'h112233DD);
    wrByte(8'h20);
    update();
    chkCtl("R10 byte stored and pointer rewound", 5'd4, 1'b0, 2'd0, 32'h11223344);

    // R7: serial load, LSB first; C3 -> phase 24, pd 0, fmt 3
    curReq = "R7";
    @(negedge clk);
    serialMode = 1'b1;
    begin
      logic [39:0] sw;
      sw = 40'hC3_CAFEF00D;
      for (int i = 0; i < 40; i++) wrByte({sw[i], 7'b0});
    end
    update();
    chkCtl("R7 serial word", 5'd24, 1'b0, 2'd3, 32'hCAFEF00D);
    serialMode = 1'b0;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule